// File: doc/BRIEF.md
# Terminal Layer-1 Activation Controller

This block runs the layer-1 activation procedure of a terminal attached to a basic-rate digital subscriber line. The line transceiver reports line conditions as 4-bit indication codes framed in a byte on a command/indication channel. Layer 2 asks for activation with a one-cycle request. The controller follows a fixed transition table over eight activation states. It answers the transceiver with framed 4-bit command codes and raises one-cycle activate and deactivate indications toward layer 2.

The block holds a supervision timer for activation. The timer is armed when layer 2 asks for activation while the line is powered down. If the line has not reached the active state when the timer runs out, the block tells the transceiver to deactivate and reports the failure to layer 2. A transmit-enable flag is high only while the link is active, so the data path can use it to gate transmission. All outputs are registered. Each one changes on the clock edge that samples the causing input.

Top module: `l1_act_ctrl`

## Requirements
- R1: While reset is asserted, and after it, the state output reads 0 (reset) and every pulse output is low. State codes are reset 0, F3-powered-down 1, F3-pending 2, F4 3, F5 4, F6 5, F7 (active) 6 and F8 7. The reset command byte 0x07 is sent once, on the third rising edge after reset is released. Indications that arrive before or during that edge are not acted on.
- R2: An indication is taken only when the receive strobe is high and bit 1 (the change bit) of the byte is set. The code is read from bits 5:2. A byte with bit 1 clear has no effect.
- R3: A command is sent as a one-cycle transmit strobe with the byte {2'b00, code, 2'b11}: deactivate 1111 gives 0x3F, activate request 1000 gives 0x23, reset 0001 gives 0x07. All outputs respond on the rising edge that samples the input.
- R4: RES (0001) or EI (0110) moves any state to reset and sends deactivate. Only when leaving F7 does it also raise the deactivate indication.
- R5: AI8 (1100) in any state other than F7 moves to F7, sends activate request, raises the activate indication and stops the timer. AI8 in F7 has no effect.
- R6: DC (1111) moves reset, F3-pending, F4, F5, F6 and F8 to F3-powered-down. It has no effect in F3-powered-down or F7.
- R7: An activate request in F3-powered-down sends activate request, keeps the state and arms the timer. A repeat request re-arms the timer. In any other state the request has no effect.
- R8: Progress toward activation follows these codes. PU (0111) moves F3-powered-down to F4. RSY (0100) moves F3-powered-down, F3-pending and F4 to F5, and moves F6 to F8. AR (1000) moves reset, F3-powered-down, F3-pending, F5 and F8 to F6.
- R9: DR (0000) in F5 or F8, and DR6 (0101) in F6, move to F3-pending and send deactivate.
- R10: In F7, AR moves to F6, RSY to F8, and DR to F3-pending with deactivate sent. Each of these raises the deactivate indication.
- R11: The timer expires T3_CYCLES rising edges after the edge that armed it, and fires once. On expiry in F3-powered-down, F4, F5, F6 or F8 the block sends deactivate and raises the deactivate indication without a state change. Expiry in reset, F3-pending or F7 has no effect.
- R12: The deactivate request, SLD (0011), and any code/state pair not listed above have no effect. In one cycle an indication takes precedence over an activate request, and either one takes precedence over timer expiry. The lower-priority event is dropped.
- R13: The transmit-enable output is high exactly while the state is F7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ci_rx_byte | input | 8 | Received indication byte |
| ci_rx_strobe | input | 1 | Received byte valid |
| l2_act_req | input | 1 | Layer-2 activate request pulse |
| l2_deact_req | input | 1 | Layer-2 deactivate request pulse (ignored) |
| ci_tx_byte | output | 8 | Framed command byte |
| ci_tx_strobe | output | 1 | Command byte valid, one cycle |
| l2_act_ind | output | 1 | Activate indication pulse |
| l2_deact_ind | output | 1 | Deactivate indication pulse |
| l1_state | output | 3 | Current activation state code |
| tx_enable | output | 1 | High while the link is active |

## Verification
The hardest case to reach is a timer that is still armed while the block sits in a state where expiry must be silent. It only happens when the line moves away after an activation request without reaching F7. The bench arms the timer in F3-powered-down, then walks through F6 to F3-pending with AR and DR6. It then idles past the expiry point and checks that neither a command nor an indication appears. Other sequences check expiry in F3-powered-down and F4, cancellation by AI8, re-arming by a second request, and an indication and a request arriving in the same cycle.

// File: rtl/l1a_pkg.sv
package l1a_pkg;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_F3_PD   = 3'd1,
    ST_F3_PEND = 3'd2,
    ST_F4      = 3'd3,
    ST_F5      = 3'd4,
    ST_F6      = 3'd5,
    ST_F7      = 3'd6,
    ST_F8      = 3'd7
  } l1_state_e;

  localparam int CODE_W = 4;

  // received indication codes
  localparam logic [CODE_W-1:0] IND_DR  = 4'h0;
  localparam logic [CODE_W-1:0] IND_RES = 4'h1;
  localparam logic [CODE_W-1:0] IND_RSY = 4'h4;
  localparam logic [CODE_W-1:0] IND_DR6 = 4'h5;
  localparam logic [CODE_W-1:0] IND_EI  = 4'h6;
  localparam logic [CODE_W-1:0] IND_PU  = 4'h7;
  localparam logic [CODE_W-1:0] IND_AR  = 4'h8;
  localparam logic [CODE_W-1:0] IND_AI8 = 4'hC;
  localparam logic [CODE_W-1:0] IND_DC  = 4'hF;

  // transmitted command codes
  localparam logic [CODE_W-1:0] CMD_DI  = 4'hF;
  localparam logic [CODE_W-1:0] CMD_AR8 = 4'h8;
  localparam logic [CODE_W-1:0] CMD_RES = 4'h1;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] code;
  } ci_word_t;

endpackage

// File: rtl/ci_rx_decode.sv
module ci_rx_decode
  import l1a_pkg::*;
#(
  parameter int CI_W = 8
) (
  input  logic [CI_W-1:0] rx_byte,
  input  logic            rx_strobe,
  output ci_word_t        word
);
  localparam int CHG_BIT = 1;
  localparam int LSB     = 2;
  localparam int MSB     = LSB + CODE_W - 1;

  logic unused_rx_bits;

  always_comb begin
    word.valid = rx_strobe & rx_byte[CHG_BIT];
    word.code  = rx_byte[MSB:LSB];
  end

  assign unused_rx_bits = ^{rx_byte[CI_W-1:MSB+1], rx_byte[0]};

endmodule

// File: rtl/t3_timer.sv
module t3_timer #(
  parameter int T3_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic expire
);
  localparam int CW = $clog2(T3_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(T3_CYCLES);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = RELOAD;
      run_d = 1'b1;
    end else if (stop) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start || stop || run_q) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign expire = run_q && (cnt_q == ONE);

  // R11: expiry is a single pulse
  assert_t3_single_shot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !expire);

  // R7: arming loads the full window
  assert_t3_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && cnt_q == RELOAD));

endmodule

// File: rtl/l1_act_fsm.sv
module l1_act_fsm
  import l1a_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ci_word_t          ind,
  input  logic              act_req,
  input  logic              t3_expire,
  output l1_state_e         state_q,
  output logic              cmd_req,
  output logic [CODE_W-1:0] cmd_code,
  output logic              act_ind_q,
  output logic              deact_ind_q,
  output logic              t3_start,
  output logic              t3_stop
);
  l1_state_e state_d;
  logic      act_d, deact_d;
  logic      boot_q;

  function automatic logic expiry_live(l1_state_e s);
    return (s == ST_F3_PD) || (s == ST_F4) || (s == ST_F5) ||
           (s == ST_F6) || (s == ST_F8);
  endfunction

  always_comb begin
    state_d  = state_q;
    cmd_req  = 1'b0;
    cmd_code = CMD_DI;
    act_d    = 1'b0;
    deact_d  = 1'b0;
    t3_start = 1'b0;
    t3_stop  = 1'b0;
    if (!boot_q) begin
      cmd_req  = 1'b1;
      cmd_code = CMD_RES;
    end else if (ind.valid) begin
      unique case (ind.code)
        IND_RES, IND_EI: begin
          state_d = ST_RESET;
          cmd_req = 1'b1;
          deact_d = (state_q == ST_F7);
        end
        IND_AI8: if (state_q != ST_F7) begin
          state_d  = ST_F7;
          cmd_req  = 1'b1;
          cmd_code = CMD_AR8;
          act_d    = 1'b1;
          t3_stop  = 1'b1;
        end
        IND_DC: if (state_q != ST_F3_PD && state_q != ST_F7) state_d = ST_F3_PD;
        IND_PU: if (state_q == ST_F3_PD) state_d = ST_F4;
        IND_AR: begin
          unique case (state_q)
            ST_RESET, ST_F3_PD, ST_F3_PEND, ST_F5, ST_F8: state_d = ST_F6;
            ST_F7: begin state_d = ST_F6; deact_d = 1'b1; end
            default: ;
          endcase
        end
        IND_RSY: begin
          unique case (state_q)
            ST_F3_PD, ST_F3_PEND, ST_F4: state_d = ST_F5;
            ST_F6: state_d = ST_F8;
            ST_F7: begin state_d = ST_F8; deact_d = 1'b1; end
            default: ;
          endcase
        end
        IND_DR: begin
          if (state_q == ST_F5 || state_q == ST_F8 || state_q == ST_F7) begin
            state_d = ST_F3_PEND;
            cmd_req = 1'b1;
            deact_d = (state_q == ST_F7);
          end
        end
        IND_DR6: if (state_q == ST_F6) begin
          state_d = ST_F3_PEND;
          cmd_req = 1'b1;
        end
        default: ;
      endcase
    end else if (act_req) begin
      if (state_q == ST_F3_PD) begin
        cmd_req  = 1'b1;
        cmd_code = CMD_AR8;
        t3_start = 1'b1;
      end
    end else if (t3_expire) begin
      if (expiry_live(state_q)) begin
        cmd_req = 1'b1;
        deact_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RESET;
      act_ind_q   <= 1'b0;
      deact_ind_q <= 1'b0;
      boot_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      act_ind_q   <= act_d;
      deact_ind_q <= deact_d;
      if (!boot_q) boot_q <= 1'b1;
    end
  end

  // R5: an activate indication marks entry into F7
  assert_act_enters_f7_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_ind_q |-> (state_q == ST_F7 && $past(state_q) != ST_F7));

  // R10: leaving F7 always reports deactivation
  assert_f7_exit_reports_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_F7 && state_q != ST_F7) |-> deact_ind_q);

  // R4: never both indications at once
  assert_one_indication_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_ind_q && deact_ind_q));

  // R12: without an accepted indication the state holds
  assert_state_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ind.valid |=> $stable(state_q));

endmodule

// File: rtl/ci_tx_frame.sv
module ci_tx_frame
  import l1a_pkg::*;
#(
  parameter int CI_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_req,
  input  logic [CODE_W-1:0] cmd_code,
  output logic [CI_W-1:0]   tx_byte,
  output logic              tx_strobe
);
  localparam int PAD_W = CI_W - CODE_W - 2;

  logic [CI_W-1:0] byte_d;

  always_comb byte_d = {{PAD_W{1'b0}}, cmd_code, 2'b11};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte   <= '0;
      tx_strobe <= 1'b0;
    end else begin
      tx_strobe <= cmd_req;
      if (cmd_req) tx_byte <= byte_d;
    end
  end

  // R3: a strobed byte carries the framing bits and follows a request
  assert_tx_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> (tx_byte[1:0] == 2'b11 && $past(cmd_req)));

endmodule

// File: rtl/l1_act_ctrl.sv
module l1_act_ctrl
  import l1a_pkg::*;
#(
  parameter int CI_W      = 8,
  parameter int T3_CYCLES = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CI_W-1:0] ci_rx_byte,
  input  logic            ci_rx_strobe,
  input  logic            l2_act_req,
  input  logic            l2_deact_req,
  output logic [CI_W-1:0] ci_tx_byte,
  output logic            ci_tx_strobe,
  output logic            l2_act_ind,
  output logic            l2_deact_ind,
  output logic [2:0]      l1_state,
  output logic            tx_enable
);
  logic              rst_meta_q, rst_sync_n;
  ci_word_t          ind;
  l1_state_e         state_q;
  logic              cmd_req, t3_start, t3_stop, t3_expire;
  logic [CODE_W-1:0] cmd_code;
  logic              unused_deact_req;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ci_rx_decode #(.CI_W(CI_W)) u_rx (
    .rx_byte   (ci_rx_byte),
    .rx_strobe (ci_rx_strobe),
    .word      (ind)
  );

  l1_act_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ind         (ind),
    .act_req     (l2_act_req),
    .t3_expire   (t3_expire),
    .state_q     (state_q),
    .cmd_req     (cmd_req),
    .cmd_code    (cmd_code),
    .act_ind_q   (l2_act_ind),
    .deact_ind_q (l2_deact_ind),
    .t3_start    (t3_start),
    .t3_stop     (t3_stop)
  );

  t3_timer #(.T3_CYCLES(T3_CYCLES)) u_t3 (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (t3_start),
    .stop   (t3_stop),
    .expire (t3_expire)
  );

  ci_tx_frame #(.CI_W(CI_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_req   (cmd_req),
    .cmd_code  (cmd_code),
    .tx_byte   (ci_tx_byte),
    .tx_strobe (ci_tx_strobe)
  );

  assign l1_state         = state_q;
  assign tx_enable        = (state_q == ST_F7);
  assign unused_deact_req = l2_deact_req;

  // R13: indications agree with the transmit gate
  assert_gate_tracks_ind_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (l2_act_ind |-> tx_enable) and (l2_deact_ind |-> !tx_enable));

endmodule

// File: tb/test_l1_act_ctrl.sv
module test_l1_act_ctrl;
  localparam int T3 = 12;
  localparam int NV = 33;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rx_byte;
  logic       rx_stb, act_req, deact_req;
  logic [7:0] tx_byte;
  logic       tx_stb, act_ind, deact_ind, tx_en;
  logic [2:0] state;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  l1_act_ctrl #(.CI_W(8), .T3_CYCLES(T3)) i_l1_act_ctrl (
    .clk(clk), .rst_n(rst_n), .ci_rx_byte(rx_byte), .ci_rx_strobe(rx_stb),
    .l2_act_req(act_req), .l2_deact_req(deact_req), .ci_tx_byte(tx_byte),
    .ci_tx_strobe(tx_stb), .l2_act_ind(act_ind), .l2_deact_ind(deact_ind),
    .l1_state(state), .tx_enable(tx_en)
  );

  // indication bytes: code in bits 5:2, change bit 1 set
  localparam logic [7:0] B_DR = 8'h02, B_RES = 8'h06, B_SLD = 8'h0E, B_RSY = 8'h12,
                         B_DR6 = 8'h16, B_EI = 8'h1A, B_PU = 8'h1E, B_AR = 8'h22,
                         B_AI8 = 8'h32, B_DC = 8'h3E;

  // {rx_byte, strobe, act, deact, exp_state, exp_tx_stb, exp_tx_byte, exp_act, exp_deact}
  localparam logic [24:0] VEC [NV] = '{
    {B_DC,  3'b100, 3'd1, 1'b0, 8'h00, 2'b00},  // R6 reset -> F3PD
    {8'h00, 3'b010, 3'd1, 1'b1, 8'h23, 2'b00},  // R7 act req arms timer
    {B_PU,  3'b100, 3'd3, 1'b0, 8'h00, 2'b00},  // R8 F3PD -> F4
    {B_RSY, 3'b100, 3'd4, 1'b0, 8'h00, 2'b00},  // R8 F4 -> F5
    {B_AR,  3'b100, 3'd5, 1'b0, 8'h00, 2'b00},  // R8 F5 -> F6
    {B_RSY, 3'b100, 3'd7, 1'b0, 8'h00, 2'b00},  // R8 F6 -> F8
    {B_AI8, 3'b100, 3'd6, 1'b1, 8'h23, 2'b10},  // R5 F8 -> F7
    {B_AI8, 3'b100, 3'd6, 1'b0, 8'h00, 2'b00},  // R5 AI8 in F7 ignored
    {B_DC,  3'b100, 3'd6, 1'b0, 8'h00, 2'b00},  // R6 DC in F7 ignored
    {8'h20, 3'b100, 3'd6, 1'b0, 8'h00, 2'b00},  // R2 change bit clear
    {8'h00, 3'b001, 3'd6, 1'b0, 8'h00, 2'b00},  // R12 deact req ignored
    {B_RSY, 3'b100, 3'd7, 1'b0, 8'h00, 2'b01},  // R10 F7 -> F8
    {B_DR,  3'b100, 3'd2, 1'b1, 8'h3F, 2'b00},  // R9 F8 -> F3PEND
    {B_AR,  3'b100, 3'd5, 1'b0, 8'h00, 2'b00},  // R8 F3PEND -> F6
    {B_DR6, 3'b100, 3'd2, 1'b1, 8'h3F, 2'b00},  // R9 F6 -> F3PEND
    {B_RSY, 3'b100, 3'd4, 1'b0, 8'h00, 2'b00},  // R8 F3PEND -> F5
    {B_DR,  3'b100, 3'd2, 1'b1, 8'h3F, 2'b00},  // R9 F5 -> F3PEND
    {B_AI8, 3'b100, 3'd6, 1'b1, 8'h23, 2'b10},  // R5 F3PEND -> F7
    {B_AR,  3'b100, 3'd5, 1'b0, 8'h00, 2'b01},  // R10 F7 -> F6
    {B_AI8, 3'b100, 3'd6, 1'b1, 8'h23, 2'b10},  // R5 F6 -> F7
    {B_DR,  3'b100, 3'd2, 1'b1, 8'h3F, 2'b01},  // R10 F7 -> F3PEND
    {B_AI8, 3'b100, 3'd6, 1'b1, 8'h23, 2'b10},  // R5
    {B_EI,  3'b100, 3'd0, 1'b1, 8'h3F, 2'b01},  // R4 EI from F7
    {B_AR,  3'b100, 3'd5, 1'b0, 8'h00, 2'b00},  // R8 reset -> F6
    {B_RES, 3'b100, 3'd0, 1'b1, 8'h3F, 2'b00},  // R4 RES from F6
    {B_SLD, 3'b100, 3'd0, 1'b0, 8'h00, 2'b00},  // R12 SLD ignored
    {8'h00, 3'b010, 3'd0, 1'b0, 8'h00, 2'b00},  // R7 act req in reset ignored
    {B_DC,  3'b000, 3'd0, 1'b0, 8'h00, 2'b00},  // R2 strobe low
    {B_DC,  3'b100, 3'd1, 1'b0, 8'h00, 2'b00},  // R6
    {B_RES, 3'b100, 3'd0, 1'b1, 8'h3F, 2'b00},  // R4 no indication outside F7
    {B_DC,  3'b100, 3'd1, 1'b0, 8'h00, 2'b00},  // R6
    {B_PU,  3'b110, 3'd3, 1'b0, 8'h00, 2'b00},  // R12 indication beats act req
    {B_RES, 3'b100, 3'd0, 1'b1, 8'h3F, 2'b00}   // R4
  };

  task automatic step(input logic [7:0] b, input logic s, input logic a, input logic d);
    @(negedge clk);
    rx_byte = b; rx_stb = s; act_req = a; deact_req = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic expect_out(input string tag, input logic [2:0] st, input logic cv,
                            input logic [7:0] cb, input logic ai, input logic di);
    logic ok;
    checks++;
    ok = (state === st) && (tx_stb === cv) && (act_ind === ai) &&
         (deact_ind === di) && (tx_en === (st == 3'd6)) && (!cv || tx_byte === cb);
    if (!ok) begin
      errors++;
      $display("FAIL %s: got st=%0d stb=%b byte=%h ai=%b di=%b en=%b, exp st=%0d stb=%b byte=%h ai=%b di=%b",
               tag, state, tx_stb, tx_byte, act_ind, deact_ind, tx_en, st, cv, cb, ai, di);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_byte = '0; rx_stb = 1'b0; act_req = 1'b0; deact_req = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 in reset", 3'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    // release with a DC held on the channel through the boot edge
    @(negedge clk);
    rst_n = 1'b1; rx_byte = B_DC; rx_stb = 1'b1;
    @(posedge clk); #1;
    expect_out("R1 edge1", 3'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    @(posedge clk); #1;
    expect_out("R1 edge2", 3'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    @(posedge clk); #1;
    expect_out("R1 reset cmd", 3'd0, 1'b1, 8'h07, 1'b0, 1'b0);
    idle();
    expect_out("R3 single strobe", 3'd0, 1'b0, 8'h00, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      step(v[24:17], v[16], v[15], v[14]);
      expect_out($sformatf("table row %0d", i), v[13:11], v[10], v[9:2], v[1], v[0]);
    end

    // R11 expiry in F3PD after T3 edges, one shot
    step(B_DC, 1'b1, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b1, 1'b0);
    expect_out("R11 arm", 3'd1, 1'b1, 8'h23, 1'b0, 1'b0);
    for (int k = 1; k <= T3 + 3; k++) begin
      idle();
      if (k == T3) expect_out("R11 expiry F3PD", 3'd1, 1'b1, 8'h3F, 1'b0, 1'b1);
      else expect_out("R11 quiet F3PD", 3'd1, 1'b0, 8'h00, 1'b0, 1'b0);
    end

    // R11 expiry in F4
    step(8'h00, 1'b0, 1'b1, 1'b0);
    step(B_PU, 1'b1, 1'b0, 1'b0);
    for (int k = 2; k <= T3; k++) idle();
    expect_out("R11 expiry F4", 3'd3, 1'b1, 8'h3F, 1'b0, 1'b1);

    // R11 expiry ignored in F3PEND
    step(B_DC, 1'b1, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b1, 1'b0);
    step(B_AR, 1'b1, 1'b0, 1'b0);
    step(B_DR6, 1'b1, 1'b0, 1'b0);
    expect_out("R9 reach F3PEND", 3'd2, 1'b1, 8'h3F, 1'b0, 1'b0);
    for (int k = 4; k <= T3 + 3; k++) begin
      idle();
      expect_out("R11 silent F3PEND", 3'd2, 1'b0, 8'h00, 1'b0, 1'b0);
    end

    // R5 AI8 stops the timer
    step(B_DC, 1'b1, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b1, 1'b0);
    step(B_AI8, 1'b1, 1'b0, 1'b0);
    expect_out("R5 AI8 F3PD", 3'd6, 1'b1, 8'h23, 1'b1, 1'b0);
    for (int k = 3; k <= T3 + 3; k++) begin
      idle();
      expect_out("R5 timer stopped", 3'd6, 1'b0, 8'h00, 1'b0, 1'b0);
    end

    // R7 second request re-arms the timer
    step(B_EI, 1'b1, 1'b0, 1'b0);
    expect_out("R4 EI F7", 3'd0, 1'b1, 8'h3F, 1'b0, 1'b1);
    step(B_DC, 1'b1, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b1, 1'b0);
    repeat (5) idle();
    step(8'h00, 1'b0, 1'b1, 1'b0);
    expect_out("R7 re-arm", 3'd1, 1'b1, 8'h23, 1'b0, 1'b0);
    for (int k = 1; k <= T3; k++) begin
      idle();
      if (k == T3) expect_out("R7 re-armed expiry", 3'd1, 1'b1, 8'h3F, 1'b0, 1'b1);
      else expect_out("R7 re-armed quiet", 3'd1, 1'b0, 8'h00, 1'b0, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule